// File: doc/BRIEF.md
# Periodic Signal Power Monitor

This block watches a stream of signed converter samples, one per clock, and reports the level of the signal once per measurement window. For each window it reports one of two measures. Peak mode gives the largest sample magnitude seen. Power mode gives the mean of the squared samples, computed as the sum of squares shifted right by the floor of log2 of the window length. That shift is an exact mean when the length is a power of two. The power value is held to 20 bits and saturates at full scale.

The window length comes from a 24-bit period input. A down-counter loaded from that input times each window. The length is taken at the start of each window, and any value below 128 is raised to 128. When a window closes, the result is latched and a valid strobe is raised for one cycle. The counter reloads in that same cycle. The sample that arrives in the closing cycle is not dropped: it becomes the first sample of the next window, so consecutive windows are contiguous.

A synchronous restart input throws away the partial window and starts a fresh one at once. It does not touch the result already held. After reset, the first active clock starts a window in the same way.

Top module: `sigpow_monitor`

## Requirements
- R1: While reset is asserted, result_o is 0 and result_valid_o is 0.
- R2: Let P = max(period_i, 128), sampled in the cycle a window starts. A window starts in the first active cycle after reset, in every cycle with restart_i high, and in the cycle after the previous window's last sample. Each window holds exactly P consecutive samples. result_valid_o is high in the cycle after the clock edge that takes a window's last sample.
- R3: With mode_i = 1 (power) in the cycle a window's result is taken, result_o = min(floor(S / 2^floor(log2 P)), 2^20 - 1). S is the sum of the squares of the window's P samples.
- R4: With mode_i = 0 (peak) in that cycle, result_o is the largest |sample| in the window, zero-extended. A sample of -1024 counts as 1024.
- R5: The sample taken in the cycle that closes a window is the first sample of the next window. No sample is left out of every window, and none is counted in two.
- R6: result_valid_o is never high in two consecutive cycles. result_o changes only in cycles where result_valid_o is high.
- R7: restart_i high discards the partial window and starts a new one with that cycle's sample as its first sample. No result is produced for the discarded window, so result_valid_o is low and result_o is unchanged in the next cycle.
- R8: A period_i value below 128, including 0 and 64, gives windows of exactly 128 samples, with the power shift taken for a length of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 11 | Two's complement input sample |
| period_i | input | 24 | Requested window length in samples |
| mode_i | input | 1 | 0 = peak magnitude, 1 = mean-square power |
| restart_i | input | 1 | Synchronous window restart |
| result_o | output | 20 | Latched result of the last completed window |
| result_valid_o | output | 1 | One-cycle strobe when result_o is updated |

## Verification
A counter that is off by one moves the valid strobe away from the sample-count boundary. The bench checks the strobe in every cycle, so the error shows at the first window end, 128 or more cycles after a start. A seed or clear error at a boundary changes the sum by one sample's power. A single large sample placed exactly on a boundary then lands in the wrong window's result. A wrong shift, clamp or saturation shows in the first result of the run that uses a non-power-of-two length, a short period or full-scale negative input. A restart that leaks the old sum or writes the result shows within one window of the restart.

// File: rtl/sigpow_pkg.sv
package sigpow_pkg;

  typedef enum logic {
    MODE_PEAK  = 1'b0,
    MODE_POWER = 1'b1
  } sigpow_mode_e;

  // floor(log2(v)) for v >= 1; 0 for v == 0
  function automatic int floor_log2(input logic [31:0] v);
    int pos;
    pos = 0;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) pos = b;
    end
    return pos;
  endfunction

endpackage

// File: rtl/sigpow_window_timer.sv
module sigpow_window_timer #(
  parameter int PERIOD_W   = 24,
  parameter int MIN_PERIOD = 128,
  parameter int SHIFT_W    = $clog2(PERIOD_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                win_seed_o,
  output logic                win_end_o,
  output logic [SHIFT_W-1:0]  shift_o
);
  import sigpow_pkg::*;

  localparam logic [PERIOD_W-1:0] FLOOR_LEN = PERIOD_W'(MIN_PERIOD);
  localparam logic [PERIOD_W-1:0] ONE       = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [SHIFT_W-1:0]  shift_q, shift_d;
  logic [PERIOD_W-1:0] eff_len;
  logic                idle, last, load;

  // window length after the floor clamp
  always_comb begin
    if (period_i < FLOOR_LEN) eff_len = FLOOR_LEN;
    else                      eff_len = period_i;
  end

  assign idle = (cnt_q == '0);
  assign last = (cnt_q == ONE);
  assign load = restart_i | idle | last;

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    if (load) begin
      cnt_d   = eff_len;
      shift_d = SHIFT_W'(floor_log2(32'(eff_len)));
    end else begin
      cnt_d   = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
    end
  end

  assign win_seed_o = load;
  assign win_end_o  = last & ~restart_i;
  assign shift_o    = shift_q;

endmodule

// File: rtl/sigpow_power_accum.sv
module sigpow_power_accum #(
  parameter int SAMPLE_W = 11,
  parameter int PERIOD_W = 24,
  parameter int ACC_W    = 2 * SAMPLE_W + PERIOD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       seed_i,
  output logic [ACC_W-1:0]           acc_o
);
  localparam int SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0] sq_s;
  logic [ACC_W-1:0]       sq_ext;
  logic [ACC_W-1:0]       acc_q, acc_d;

  always_comb begin
    sq_s   = SQ_W'(sample_i) * SQ_W'(sample_i);
    sq_ext = ACC_W'(unsigned'(sq_s));
  end

  always_comb begin
    if (seed_i) acc_d = sq_ext;
    else        acc_d = acc_q + sq_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sigpow_peak_track.sv
module sigpow_peak_track #(
  parameter int SAMPLE_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       seed_i,
  output logic [SAMPLE_W-1:0]        peak_o
);
  logic signed [SAMPLE_W:0] ext_s, neg_s;
  logic [SAMPLE_W-1:0]      mag;
  logic [SAMPLE_W-1:0]      peak_q, peak_d;

  // magnitude; the most negative code maps to 2^(SAMPLE_W-1)
  always_comb begin
    ext_s = {sample_i[SAMPLE_W-1], sample_i};
    neg_s = -ext_s;
    if (ext_s[SAMPLE_W]) mag = neg_s[SAMPLE_W-1:0];
    else                 mag = ext_s[SAMPLE_W-1:0];
  end

  always_comb begin
    if (seed_i)           peak_d = mag;
    else if (mag > peak_q) peak_d = mag;
    else                  peak_d = peak_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= '0;
    else        peak_q <= peak_d;
  end

  assign peak_o = peak_q;

endmodule

// File: rtl/sigpow_result_stage.sv
module sigpow_result_stage #(
  parameter int SAMPLE_W = 11,
  parameter int ACC_W    = 46,
  parameter int RESULT_W = 20,
  parameter int SHIFT_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_end_i,
  input  logic                mode_i,
  input  logic [ACC_W-1:0]    acc_i,
  input  logic [SAMPLE_W-1:0] peak_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                valid_o
);
  import sigpow_pkg::*;

  logic [ACC_W-1:0]    mean;
  logic                over;
  logic [RESULT_W-1:0] power_val, peak_val, pick;
  logic [RESULT_W-1:0] result_q, result_d;
  logic                valid_q, valid_d;

  always_comb begin
    mean      = acc_i >> shift_i;
    over      = |mean[ACC_W-1:RESULT_W];
    power_val = over ? {RESULT_W{1'b1}} : mean[RESULT_W-1:0];
    peak_val  = RESULT_W'(peak_i);
    pick      = (sigpow_mode_e'(mode_i) == MODE_POWER) ? power_val : peak_val;
  end

  always_comb begin
    result_d = result_q;
    valid_d  = 1'b0;
    if (win_end_i) begin
      result_d = pick;
      valid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/sigpow_monitor.sv
module sigpow_monitor #(
  parameter int SAMPLE_W   = 11,
  parameter int PERIOD_W   = 24,
  parameter int RESULT_W   = 20,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                mode_i,
  input  logic                restart_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                result_valid_o
);
  localparam int ACC_W   = 2 * SAMPLE_W + PERIOD_W;
  localparam int SHIFT_W = $clog2(PERIOD_W);

  logic                       win_seed, win_end;
  logic [SHIFT_W-1:0]         shift;
  logic [ACC_W-1:0]           acc;
  logic [SAMPLE_W-1:0]        peak;
  logic signed [SAMPLE_W-1:0] sample_s;

  assign sample_s = signed'(sample_i);

  sigpow_window_timer #(
    .PERIOD_W  (PERIOD_W),
    .MIN_PERIOD(MIN_PERIOD),
    .SHIFT_W   (SHIFT_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .period_i  (period_i),
    .win_seed_o(win_seed),
    .win_end_o (win_end),
    .shift_o   (shift)
  );

  sigpow_power_accum #(
    .SAMPLE_W(SAMPLE_W),
    .PERIOD_W(PERIOD_W),
    .ACC_W   (ACC_W)
  ) accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample_i(sample_s),
    .seed_i  (win_seed),
    .acc_o   (acc)
  );

  sigpow_peak_track #(
    .SAMPLE_W(SAMPLE_W)
  ) peak_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample_i(sample_s),
    .seed_i  (win_seed),
    .peak_o  (peak)
  );

  sigpow_result_stage #(
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .RESULT_W(RESULT_W),
    .SHIFT_W (SHIFT_W)
  ) result_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_end_i(win_end),
    .mode_i   (mode_i),
    .acc_i    (acc),
    .peak_i   (peak),
    .shift_i  (shift),
    .result_o (result_o),
    .valid_o  (result_valid_o)
  );

endmodule

// File: rtl/sigpow_monitor_chk.sv
module sigpow_monitor_chk #(
  parameter int SAMPLE_W   = 11,
  parameter int PERIOD_W   = 24,
  parameter int RESULT_W   = 20,
  parameter int MIN_PERIOD = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_i,
  input logic                restart_i,
  input logic [RESULT_W-1:0] result_o,
  input logic                result_valid_o
);
  localparam int GAP_W = PERIOD_W + 1;
  localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(MIN_PERIOD - 1);
  localparam logic [GAP_W-1:0] GAP_TOP  = {GAP_W{1'b1}};
  localparam logic [RESULT_W-1:0] PK_MAX = RESULT_W'(1) << (SAMPLE_W - 1);

  logic [GAP_W-1:0] gap_q;

  // cycles since the last strobe or restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_q <= '0;
    else if (restart_i || result_valid_o) gap_q <= '0;
    else if (gap_q != GAP_TOP)           gap_q <= gap_q + GAP_W'(1);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (result_o == '0 && !result_valid_o);
    end
  end

  p_window_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> gap_q >= GAP_MIN);

  p_peak_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && !$past(mode_i)) |-> result_o <= PK_MAX);

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));

  p_restart_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !result_valid_o);

endmodule

bind sigpow_monitor sigpow_monitor_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .PERIOD_W  (PERIOD_W),
  .RESULT_W  (RESULT_W),
  .MIN_PERIOD(MIN_PERIOD)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_i        (mode_i),
  .restart_i     (restart_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o)
);

// File: tb/sigpow_monitor_tb_top.sv
`timescale 1ns/1ps
module sigpow_monitor_tb_top;

  logic        clk;
  logic        rst_n;
  logic [10:0] sample_i;
  logic [23:0] period_i;
  logic        mode_i;
  logic        restart_i;
  logic [19:0] result_o;
  logic        result_valid_o;

  int total = 0;
  int bad   = 0;
  int last_res = 0;
  bit finished = 0;

  sigpow_monitor dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_i      (sample_i),
    .period_i      (period_i),
    .mode_i        (mode_i),
    .restart_i     (restart_i),
    .result_o      (result_o),
    .result_valid_o(result_valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // sample pattern generator, i = sample index within a run
  function automatic int gen(input int pat, input int i, input int p);
    int v;
    case (pat)
      0: v = 300;
      1: v = ((i * 7) % 2048) - 1024;
      3: v = -1024;
      4: v = ((i * i * 13 + i * 5 + 17) % 2048) - 1024;
      5: v = (i == p) ? 900 : 3;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic int flog2(input int v);
    int r = 0;
    for (int b = 0; b < 31; b++) if ((v >> b) & 1) r = b;
    return r;
  endfunction

  function automatic int expect_win(input bit pw, input int pat, input int k, input int p);
    longint sum = 0;
    int pk = 0;
    int s;
    for (int j = k * p; j < (k + 1) * p; j++) begin
      s = gen(pat, j, p);
      sum += longint'(s) * longint'(s);
      if ((s < 0 ? -s : s) > pk) pk = (s < 0 ? -s : s);
    end
    if (!pw) return pk;
    sum = sum >>> flog2(p);
    if (sum > 1048575) sum = 1048575;
    return int'(sum);
  endfunction

  // one run: window start at cycle 0 (reset release or restart)
  task automatic run(input bit pw, input int period, input int nwin, input int tail,
                     input int pat, input bit from_reset, input string req);
    int p;
    int cyc;
    int k;
    p   = (period < 128) ? 128 : period;
    cyc = nwin * p + 1 + tail;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (from_reset && i == 0) rst_n = 1'b1;
      sample_i  = 11'(gen(pat, i, p));
      period_i  = 24'(period);
      mode_i    = pw;
      restart_i = (!from_reset && i == 0);
      @(posedge clk);
      #1;
      if (i >= p && (i % p) == 0 && (i / p) <= nwin) begin
        k = i / p - 1;
        last_res = expect_win(pw, pat, k, p);
        chk(result_valid_o === 1'b1, {"R2 strobe at window end ", req}, int'(result_valid_o), 1);
        chk(result_o === 20'(last_res), req, int'(result_o), last_res);
      end else begin
        if (i == 0 && !from_reset)
          chk(result_valid_o === 1'b0 && result_o === 20'(last_res),
              "R7 restart keeps result", int'(result_o), last_res);
        else
          chk(result_valid_o === 1'b0 && result_o === 20'(last_res),
              "R6 strobe off and result held", int'(result_o), last_res);
      end
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    sample_i  = '0;
    period_i  = 24'd128;
    mode_i    = 1'b1;
    restart_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(result_o === '0 && result_valid_o === 1'b0, "R1 reset state", int'(result_o), 0);
    end
    // R3 power, first window starts at reset release
    run(1'b1, 128, 3, 0, 0, 1'b1, "R3 power constant");
    run(1'b0, 128, 3, 0, 1, 1'b0, "R4 peak ramp");
    run(1'b1, 128, 3, 0, 4, 1'b0, "R3 power mixed");
    run(1'b1, 128, 2, 0, 3, 1'b0, "R3 power saturation");
    run(1'b0, 128, 2, 0, 3, 1'b0, "R4 peak of most negative");
    run(1'b1, 128, 2, 0, 5, 1'b0, "R5 boundary sample power");
    run(1'b0, 128, 2, 0, 5, 1'b0, "R5 boundary sample peak");
    run(1'b1, 200, 3, 0, 4, 1'b0, "R3 power non-power-of-two");
    run(1'b0, 200, 2, 0, 1, 1'b0, "R4 peak length 200");
    run(1'b1, 0, 2, 0, 1, 1'b0, "R8 clamp period 0");
    run(1'b1, 64, 2, 0, 4, 1'b0, "R8 clamp period 64");
    // partial window then restart: R7
    run(1'b1, 128, 1, 60, 4, 1'b0, "R7 before restart");
    run(1'b0, 128, 2, 0, 4, 1'b0, "R7 window after restart");
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule